// File: doc/BRIEF.md
# PWM Input High/Low Capture

This unit measures an incoming pulse train against the local reference clock. It counts how many clock cycles each high phase lasts and how many each low phase lasts. When a phase ends, it holds the result in one of two separate result registers. The input is asynchronous to the clock, so it first passes through a flop synchronizer. Both edge directions are then detected on the synchronized copy.

Each kind of result has its own sticky status bit. Software clears a status bit by writing a one to it. Each status bit also has an interrupt-enable bit, and one interrupt line combines the enabled sources. Measurement runs only while the shared mode selector holds the capture code and both the run and counting-clock enables are set. In any other setting the phase counter stays idle, and the results and status are left as they were.

Top module: `pwmcap_top`

## Requirements
- R1: Measurement is active only when `mode` equals `CAP_MODE` (default 2'b10) and both `run_en` and `cnt_clk_en` are 1. While inactive, `hi_count`, `lo_count` and `status` never change because of `sig_in`.
- R2: `sig_in` passes through a two-flop synchronizer before edge detection. A phase that lasts N clock cycles is reported as exactly N.
- R3: When the synchronized input falls, the running count is loaded into `hi_count` and `status` bit 1 (high-capture) is set.
- R4: When the synchronized input rises, the running count is loaded into `lo_count` and `status` bit 0 (low-capture) is set.
- R5: The first edge seen after measurement becomes active only restarts the counter. It loads no result and sets no status bit, so a partial phase is never reported. The next edge latches normally.
- R6: The phase counter saturates at 2^CNT_W-1 and does not wrap. A phase longer than that is reported as 2^CNT_W-1.
- R7: When `clr_wr` is 1, each `status` bit whose `clr_data` bit is 1 is cleared, and bits written with 0 keep their value. A capture in the same cycle wins over the clear.
- R8: `irq` is 1 exactly when some `status` bit is 1 and the `int_en` bit at the same position is 1 (bit 0 low-capture, bit 1 high-capture).
- R9: After reset, `hi_count`, `lo_count`, `status` and `irq` are all 0.
- R10: `hi_count` and `lo_count` keep their last values while measurement is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; every count is in cycles of this clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 1 | Asynchronous signal to be measured |
| mode | input | MODE_W | Shared function selector; capture when equal to CAP_MODE |
| run_en | input | 1 | Function enable |
| cnt_clk_en | input | 1 | Counting-clock enable |
| int_en | input | 2 | Interrupt enables: bit 0 low-capture, bit 1 high-capture |
| clr_wr | input | 1 | Status write strobe |
| clr_data | input | 2 | Write-one-to-clear mask for the status bits |
| hi_count | output | CNT_W | Last high-phase length |
| lo_count | output | CNT_W | Last low-phase length |
| status | output | 2 | Sticky capture status: bit 0 low, bit 1 high |
| irq | output | 1 | Combined interrupt request |

## Verification
A counter that is off by one, or a synchronizer of the wrong depth, shows up at the first full period as a result one cycle too long or too short. A missing first-edge discard shows up as a status bit set within three cycles of the first input edge after activation. A counter that wraps instead of saturating gives a small `hi_count` after one over-long phase. Wrong gating or wrong clear masking shows up on `status` and `irq` on the clock edge right after the offending input or write.

// File: rtl/pwmcap_pkg.sv
// Shared definitions for the PWM capture unit: status bit positions and the
// edge classification passed from the synchronizer to the phase counter.
package pwmcap_pkg;
    localparam int STS_LO  = 0;
    localparam int STS_HI  = 1;
    localparam int NUM_SRC = 2;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2
    } edge_e;
endpackage

// File: rtl/pwmcap_sync.sv
// Synchronizer and edge classifier.
// Brings the asynchronous input into the clock domain through STAGES flops,
// keeps one more flop of history and reports a rise or fall for one cycle.
// Assumes the input is stable for at least one clock to be seen reliably.
module pwmcap_sync
    import pwmcap_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  async_in,
    output edge_e edge_kind
);
    localparam int LAST = STAGES;

    logic [LAST:0] sh_q;

    // Shift the input through the synchronizer and the history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[LAST-1:0], async_in};
    end

    // Classify the change between the synchronized value and its history.
    always_comb begin
        if (sh_q[LAST-1] && !sh_q[LAST])      edge_kind = EDGE_RISE;
        else if (!sh_q[LAST-1] && sh_q[LAST]) edge_kind = EDGE_FALL;
        else                                  edge_kind = EDGE_NONE;
    end
endmodule

// File: rtl/pwmcap_phase_ctr.sv
// Phase counter and result registers.
// Counts clock cycles since the last edge, saturating at the top value. On a
// fall it loads the high result and on a rise the low result, but only once
// armed by a first edge seen while capture is active. The load strobes are
// combinational so the status flags can be set on the same edge.
module pwmcap_phase_ctr
    import pwmcap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_on,
    input  edge_e            edge_kind,
    output logic [CNT_W-1:0] hi_q,
    output logic [CNT_W-1:0] lo_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             hi_stb,
    output logic             lo_stb
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic armed_q;
    logic any_edge;

    // Decode which result, if any, is loaded this cycle.
    always_comb begin
        any_edge = (edge_kind != EDGE_NONE);
        hi_stb   = cap_on && armed_q && (edge_kind == EDGE_FALL);
        lo_stb   = cap_on && armed_q && (edge_kind == EDGE_RISE);
    end

    // Run the saturating phase counter and the arming flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !cap_on) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (any_edge) begin
            cnt_q   <= CNT_W'(1);
            armed_q <= 1'b1;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q   <= cnt_q + CNT_W'(1);
        end
    end

    // Hold the finished phase lengths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (hi_stb) hi_q <= cnt_q;
            if (lo_stb) lo_q <= cnt_q;
        end
    end
endmodule

// File: rtl/pwmcap_irq_regs.sv
// Sticky status flags with write-one-to-clear and the interrupt combiner.
// A set request in the same cycle as a clear of the same bit keeps the bit set.
module pwmcap_irq_regs
    import pwmcap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_req,
    input  logic               clr_wr,
    input  logic [NUM_SRC-1:0] clr_data,
    input  logic [NUM_SRC-1:0] int_en,
    output logic [NUM_SRC-1:0] sts_q,
    output logic               irq
);
    logic [NUM_SRC-1:0] clr_mask;

    // Form the clear mask from the write strobe.
    always_comb clr_mask = clr_wr ? clr_data : '0;

    // Update sticky flags: clear written ones, then apply new captures.
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (sts_q & ~clr_mask) | set_req;
    end

    // Combine enabled flags into one request line.
    always_comb irq = |(sts_q & int_en);
endmodule

// File: rtl/pwmcap_top.sv
// PWM input high/low capture unit, top level.
// Gates measurement with the shared mode selector and both enables, then
// chains synchronizer, phase counter and status logic.
module pwmcap_top
    import pwmcap_pkg::*;
#(
    parameter int               CNT_W    = 16,
    parameter int               MODE_W   = 2,
    parameter logic [MODE_W-1:0] CAP_MODE = 2,
    parameter int               SYNC_STG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sig_in,
    input  logic [MODE_W-1:0] mode,
    input  logic              run_en,
    input  logic              cnt_clk_en,
    input  logic [1:0]        int_en,
    input  logic              clr_wr,
    input  logic [1:0]        clr_data,
    output logic [CNT_W-1:0]  hi_count,
    output logic [CNT_W-1:0]  lo_count,
    output logic [1:0]        status,
    output logic              irq
);
    logic               cap_on;
    edge_e              edge_kind;
    logic               edge_any;
    logic [CNT_W-1:0]   cnt_q;
    logic               hi_stb;
    logic               lo_stb;
    logic [NUM_SRC-1:0] set_req;

    // Decide whether measurement is active and gather set requests.
    always_comb begin
        cap_on           = (mode == CAP_MODE) && run_en && cnt_clk_en;
        edge_any         = (edge_kind != EDGE_NONE);
        set_req          = '0;
        set_req[STS_LO]  = lo_stb;
        set_req[STS_HI]  = hi_stb;
    end

    pwmcap_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_in  (sig_in),
        .edge_kind (edge_kind)
    );

    pwmcap_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_on    (cap_on),
        .edge_kind (edge_kind),
        .hi_q      (hi_count),
        .lo_q      (lo_count),
        .cnt_q     (cnt_q),
        .hi_stb    (hi_stb),
        .lo_stb    (lo_stb)
    );

    pwmcap_irq_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_req  (set_req),
        .clr_wr   (clr_wr),
        .clr_data (clr_data),
        .int_en   (int_en),
        .sts_q    (status),
        .irq      (irq)
    );
endmodule

// File: rtl/pwmcap_chk.sv
// Property checker for pwmcap_top, attached by the bind below.
// Watches the gating, the latch-to-status path, clearing and saturation.
module pwmcap_chk
    import pwmcap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cap_on,
    input logic             edge_any,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] hi_count,
    input logic [CNT_W-1:0] lo_count,
    input logic             hi_stb,
    input logic             lo_stb,
    input logic             clr_wr,
    input logic [1:0]       clr_data,
    input logic [1:0]       status
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assert_hi_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_count != $past(hi_count)) |-> $past(cap_on));

    assert_lo_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_count != $past(lo_count)) |-> $past(cap_on));

    assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_on && edge_any) |=> (cnt_q == CNT_W'(1)));

    assert_hi_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hi_stb |=> status[STS_HI]);

    assert_lo_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lo_stb |=> status[STS_LO]);

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_on && !edge_any && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

    assert_clear_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_data[STS_LO] && !lo_stb) |=> !status[STS_LO]);

    assert_clear_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_data[STS_HI] && !hi_stb) |=> !status[STS_HI]);
endmodule

bind pwmcap_top pwmcap_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_on   (cap_on),
    .edge_any (edge_any),
    .cnt_q    (cnt_q),
    .hi_count (hi_count),
    .lo_count (lo_count),
    .hi_stb   (hi_stb),
    .lo_stb   (lo_stb),
    .clr_wr   (clr_wr),
    .clr_data (clr_data),
    .status   (status)
);

// File: tb/sim_pwmcap_top.sv
`timescale 1ns/1ps
module sim_pwmcap_top;
    localparam int CNT_W = 8;
    localparam int NVEC  = 6;
    // high length, low length per entry
    localparam int VEC [NVEC][2] = '{'{3,5}, '{1,1}, '{7,2}, '{10,20}, '{2,9}, '{40,3}};

    logic             clk = 1'b0;
    logic             rst_n;
    logic             sig_in;
    logic [1:0]       mode;
    logic             run_en;
    logic             cnt_clk_en;
    logic [1:0]       int_en;
    logic             clr_wr;
    logic [1:0]       clr_data;
    logic [CNT_W-1:0] hi_count;
    logic [CNT_W-1:0] lo_count;
    logic [1:0]       status;
    logic             irq;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    pwmcap_top #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .mode(mode),
        .run_en(run_en), .cnt_clk_en(cnt_clk_en), .int_en(int_en),
        .clr_wr(clr_wr), .clr_data(clr_data), .hi_count(hi_count),
        .lo_count(lo_count), .status(status), .irq(irq)
    );

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_period(input int h, input int l);
        sig_in = 1'b1;
        wait_cyc(h);
        sig_in = 1'b0;
        wait_cyc(l);
    endtask

    task automatic w1c(input logic [1:0] m);
        clr_wr   = 1'b1;
        clr_data = m;
        wait_cyc(1);
        clr_wr   = 1'b0;
        clr_data = 2'b00;
    endtask

    initial begin
        rst_n = 1'b0; sig_in = 1'b0; mode = 2'b00; run_en = 1'b0;
        cnt_clk_en = 1'b0; int_en = 2'b00; clr_wr = 1'b0; clr_data = 2'b00;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(1);
        chk("R9 hi_count", int'(hi_count), 0);
        chk("R9 lo_count", int'(lo_count), 0);
        chk("R9 status", int'(status), 0);
        chk("R9 irq", int'(irq), 0);

        // R1: capture mode but counting clock disabled
        mode = 2'b10; run_en = 1'b1; cnt_clk_en = 1'b0;
        for (int i = 0; i < 3; i++) drive_period(3, 4);
        chk("R1 hi_count idle", int'(hi_count), 0);
        chk("R1 lo_count idle", int'(lo_count), 0);
        chk("R1 status idle", int'(status), 0);

        // R2 R3 R4: table of phase lengths
        cnt_clk_en = 1'b1;
        for (int v = 0; v < NVEC; v++) begin
            for (int p = 0; p < 3; p++) drive_period(VEC[v][0], VEC[v][1]);
            sig_in = 1'b1;
            wait_cyc(4);
            chk("R3 hi_count", int'(hi_count), VEC[v][0]);
            chk("R4 lo_count", int'(lo_count), VEC[v][1]);
        end
        chk("R3 R4 status both", int'(status), 3);

        // R8: interrupt combining
        int_en = 2'b00; wait_cyc(1);
        chk("R8 irq masked", int'(irq), 0);
        int_en = 2'b01; wait_cyc(1);
        chk("R8 irq low src", int'(irq), 1);

        // R7: write-one-to-clear, input held high so no new captures
        w1c(2'b01);
        chk("R7 clear low", int'(status), 2);
        chk("R8 irq after clear", int'(irq), 0);
        w1c(2'b00);
        chk("R7 zero write", int'(status), 2);
        int_en = 2'b10; wait_cyc(1);
        chk("R8 irq high src", int'(irq), 1);
        w1c(2'b10);
        chk("R7 clear high", int'(status), 0);
        int_en = 2'b00;

        // R10: mode away from capture, results held
        mode = 2'b00;
        for (int i = 0; i < 3; i++) drive_period(5, 5);
        chk("R10 hi held", int'(hi_count), 40);
        chk("R10 lo held", int'(lo_count), 3);
        chk("R1 status wrong mode", int'(status), 0);

        // R5: first edge after activation is discarded
        sig_in = 1'b0; wait_cyc(4);
        mode = 2'b10; wait_cyc(2);
        sig_in = 1'b1; wait_cyc(4);
        chk("R5 lo unchanged", int'(lo_count), 3);
        chk("R5 status clear", int'(status), 0);
        wait_cyc(2);
        sig_in = 1'b0; wait_cyc(4);
        chk("R5 next fall latches", int'(hi_count), 6);
        chk("R5 high flag", int'(status), 2);

        // R6: saturation
        sig_in = 1'b1; wait_cyc(300);
        sig_in = 1'b0; wait_cyc(4);
        chk("R6 saturated", int'(hi_count), 255);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule